// File: doc/BRIEF.md
# Scan-Chain Transaction Register Bank

This block sits behind a virtual test-access port and turns a 4-bit instruction value into the choice of which data register is scanned while the data-shift state is active. Two of its registers are 72-bit windows onto transaction queues: one scans response words out of a response queue, the other scans command words into a command queue. A host can stream any number of whole words back to back in a single data-shift session, and each completed 72-bit word pops or pushes one queue entry.

Three small registers report status and give control. An 8-bit register returns the free entry count of the command queue. A single-bit register shows whether a response word is waiting. A single-bit flag drives a soft reset of the logic behind the block; software raises and then lowers it with two scans. All other instruction codes select a 1-bit bypass register. Data moves least significant bit first. Both queues sit outside the block and are reached through plain push and pop ports. The pop port is first-word-fall-through: the word is taken on the same clock edge that pop is high.

Top module: `scanTxnBank`

## Requirements
- R1: While `rstN` is low and after it is released, `softReset`, `cmdPush` and `rspPop` are 0, and the bypass path shifts out 0 first.
- R2: Instruction codes 0x0, 0x6 to 0xE and 0xF select a 1-bit bypass register: it captures 0, and during shift `tdo` shows the `tdi` bit of the previous shift edge.
- R3: Code 0x1: on the capture edge, when `rspEmpty` is 0, `rspPop` is high for that edge and the word on `rspData` is loaded. `tdo` then shows its bits from bit 0 to bit 71, one bit per shift edge.
- R4: Code 0x1: on the 72nd shift edge after the last load, the next response word is loaded (popping it when one is present), so that words stream back to back in one session.
- R5: Code 0x1: when `rspEmpty` is 1 at a load point, all 72 bits read as 0 (so the valid bit, bit 71, is 0) and `rspPop` stays low.
- R6: Code 0x2 selects an 8-bit register that captures `cmdFree` and shifts it out from bit 0 to bit 7.
- R7: Code 0x3: on the 72nd shift edge since capture, the word is complete. The first bit shifted in is bit 0. In the following cycle `cmdPush` is high for one cycle and `cmdData` holds that word.
- R8: Code 0x3: every further group of 72 shift edges in the same session pushes one more word.
- R9: Code 0x3: a partial group of fewer than 72 bits left at the update state produces no push. The next capture restarts the bit count.
- R10: Code 0x4 selects a 1-bit register that captures the inverse of `rspEmpty`.
- R11: Code 0x5 selects a 1-bit register that captures the current `softReset`. On the update edge, `softReset` takes the bit that was shifted in. An update under any other code leaves `softReset` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| irValue | input | 4 | Current virtual instruction |
| captureDr | input | 1 | Capture-DR state strobe |
| shiftDr | input | 1 | Shift-DR state strobe |
| updateDr | input | 1 | Update-DR state strobe |
| tdo | output | 1 | Serial data out (bit 0 of the selected register) |
| cmdPush | output | 1 | Push one word into the command queue |
| cmdData | output | 72 | Command word being pushed |
| cmdFree | input | 8 | Free entries in the command queue |
| rspPop | output | 1 | Pop the head of the response queue on this edge |
| rspData | input | 72 | Head word of the response queue |
| rspEmpty | input | 1 | Response queue is empty |
| softReset | output | 1 | Soft reset flag |

## Verification
Two events can land on the same edge: shifting the last bit of a streamed word and loading or pushing the next word. That same edge may also be the one where the response queue runs dry. The bench provokes this by queueing fewer response words than it scans, and by streaming two whole command words followed by a partial one. It then compares every scanned-out bit and every pushed word with values it derives from its own queue model. The pop count and the push count are checked to match exactly.

// File: rtl/scanTxnPkg.sv
package scanTxnPkg;
  typedef enum logic [2:0] {
    SEL_BYPASS,
    SEL_RSP,
    SEL_SPACE,
    SEL_CMD,
    SEL_READY,
    SEL_FLAG
  } regSel_e;

  typedef struct packed {
    logic    loadWord;
    logic    shiftEn;
    logic    update;
    regSel_e sel;
  } strobes_t;

  function automatic regSel_e decodeIr(input logic [3:0] ir);
    case (ir)
      4'h1:    return SEL_RSP;
      4'h2:    return SEL_SPACE;
      4'h3:    return SEL_CMD;
      4'h4:    return SEL_READY;
      4'h5:    return SEL_FLAG;
      default: return SEL_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/scanTxnCtrl.sv
module scanTxnCtrl
  import scanTxnPkg::*;
#(
  parameter int WORD_W = 72
) (
  input  logic     tck,
  input  logic     rstN,
  input  logic [3:0] irValue,
  input  logic     captureDr,
  input  logic     shiftDr,
  input  logic     updateDr,
  input  logic     rspEmpty,
  output strobes_t strobes,
  output logic     rspPop,
  output logic     cmdPush
);
  localparam int CNT_W = $clog2(WORD_W);

  regSel_e    sel;
  logic [CNT_W-1:0] bitCnt;
  logic       wordSel;
  logic       atBoundary;
  logic       pushPend;

  assign sel        = decodeIr(irValue);
  assign wordSel    = (sel == SEL_RSP) || (sel == SEL_CMD);
  assign atBoundary = shiftDr && wordSel && (bitCnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      pushPend <= 1'b0;
    end else begin
      pushPend <= atBoundary && (sel == SEL_CMD);
      if (captureDr)
        bitCnt <= '0;
      else if (shiftDr && wordSel)
        bitCnt <= atBoundary ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.sel      = sel;
    strobes.loadWord = captureDr || (atBoundary && (sel == SEL_RSP));
    strobes.shiftEn  = shiftDr && !strobes.loadWord;
    strobes.update   = updateDr;
  end

  assign rspPop  = (sel == SEL_RSP) && !rspEmpty && (captureDr || atBoundary);
  assign cmdPush = pushPend;

  // R7: a push is a single-cycle pulse
  a_r7_push_single: assert property (@(posedge tck) disable iff (!rstN)
    cmdPush |=> !cmdPush);
  // R9: a push only follows a shift edge under the command code
  a_r9_push_after_shift: assert property (@(posedge tck) disable iff (!rstN)
    cmdPush |-> ($past(shiftDr) && $past(irValue) == 4'h3));
  // R3: the response queue is popped only on capture or shift edges
  a_r3_pop_on_scan: assert property (@(posedge tck) disable iff (!rstN)
    rspPop |-> (captureDr || shiftDr));
endmodule

// File: rtl/scanTxnData.sv
module scanTxnData
  import scanTxnPkg::*;
#(
  parameter int WORD_W  = 72,
  parameter int SPACE_W = 8
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              tdi,
  input  strobes_t          strobes,
  input  logic [WORD_W-1:0] rspData,
  input  logic              rspEmpty,
  input  logic [SPACE_W-1:0] cmdFree,
  output logic [WORD_W-1:0] shiftReg,
  output logic              softReset
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [IDX_W-1:0]  msbIdx;
  logic [WORD_W-1:0] loadVal;
  logic [WORD_W-1:0] shiftVal;

  always_comb begin
    case (strobes.sel)
      SEL_RSP, SEL_CMD: msbIdx = IDX_W'(WORD_W - 1);
      SEL_SPACE:        msbIdx = IDX_W'(SPACE_W - 1);
      default:          msbIdx = '0;
    endcase
  end

  always_comb begin
    loadVal = '0;
    case (strobes.sel)
      SEL_RSP:   loadVal = rspEmpty ? '0 : rspData;
      SEL_SPACE: loadVal[SPACE_W-1:0] = cmdFree;
      SEL_READY: loadVal[0] = !rspEmpty;
      SEL_FLAG:  loadVal[0] = softReset;
      default:   loadVal = '0;
    endcase
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_shift
    if (i == WORD_W - 1) begin : g_top
      assign shiftVal[i] = (msbIdx == IDX_W'(i)) ? tdi : 1'b0;
    end else begin : g_mid
      assign shiftVal[i] = (msbIdx == IDX_W'(i)) ? tdi :
                           (IDX_W'(i) < msbIdx)  ? shiftReg[i+1] : 1'b0;
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      softReset <= 1'b0;
    end else begin
      if (strobes.loadWord)
        shiftReg <= loadVal;
      else if (strobes.shiftEn)
        shiftReg <= shiftVal;
      if (strobes.update && strobes.sel == SEL_FLAG)
        softReset <= shiftReg[0];
    end
  end

  // R2: a one-bit register passes tdi through with one shift of delay
  a_r2_one_bit_delay: assert property (@(posedge tck) disable iff (!rstN)
    (strobes.shiftEn && msbIdx == '0) |=> (shiftReg[0] == $past(tdi)));
  // R11: the flag moves only on an update under the flag code
  a_r11_flag_hold: assert property (@(posedge tck) disable iff (!rstN)
    !(strobes.update && strobes.sel == SEL_FLAG) |=> $stable(softReset));
endmodule

// File: rtl/scanTxnBank.sv
module scanTxnBank
  import scanTxnPkg::*;
#(
  parameter int WORD_W  = 72,
  parameter int SPACE_W = 8
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tdi,
  input  logic [3:0]         irValue,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  output logic               tdo,
  output logic               cmdPush,
  output logic [WORD_W-1:0]  cmdData,
  input  logic [SPACE_W-1:0] cmdFree,
  output logic               rspPop,
  input  logic [WORD_W-1:0]  rspData,
  input  logic               rspEmpty,
  output logic               softReset
);
  strobes_t          strobes;
  logic [WORD_W-1:0] shiftReg;

  scanTxnCtrl #(.WORD_W(WORD_W)) u_ctrl (
    .tck(tck), .rstN(rstN), .irValue(irValue), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .rspEmpty(rspEmpty),
    .strobes(strobes), .rspPop(rspPop), .cmdPush(cmdPush)
  );

  scanTxnData #(.WORD_W(WORD_W), .SPACE_W(SPACE_W)) u_data (
    .tck(tck), .rstN(rstN), .tdi(tdi), .strobes(strobes),
    .rspData(rspData), .rspEmpty(rspEmpty), .cmdFree(cmdFree),
    .shiftReg(shiftReg), .softReset(softReset)
  );

  assign tdo     = shiftReg[0];
  assign cmdData = shiftReg;

  // R5: no pop is issued towards an empty queue
  a_r5_no_pop_empty: assert property (@(posedge tck) disable iff (!rstN)
    rspEmpty |-> !rspPop);
endmodule

// File: tb/scanTxnBank_test.sv
module scanTxnBank_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 72;

  logic tck = 0, rstN = 0, tdi = 0;
  logic [3:0] irValue = 0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0;
  logic tdo, cmdPush, rspPop, softReset;
  logic [W-1:0] cmdData, rspData;
  logic [7:0] cmdFree = 0;
  logic rspEmpty;

  int vectors = 0, miscompares = 0;

  logic [W-1:0] rspMem [0:7];
  int rdPtr = 0, wrPtr = 0, popCount = 0;
  logic [W-1:0] pushed [0:7];
  int pushCount = 0;

  assign rspEmpty = (rdPtr == wrPtr);
  assign rspData  = rspMem[rdPtr % 8];

  always #(CLK_PERIOD/2) tck = ~tck;

  always @(posedge tck) begin
    if (rspPop) begin rdPtr <= rdPtr + 1; popCount <= popCount + 1; end
    if (cmdPush) begin pushed[pushCount % 8] <= cmdData; pushCount <= pushCount + 1; end
  end

  scanTxnBank uut (
    .tck(tck), .rstN(rstN), .tdi(tdi), .irValue(irValue),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdo(tdo), .cmdPush(cmdPush), .cmdData(cmdData), .cmdFree(cmdFree),
    .rspPop(rspPop), .rspData(rspData), .rspEmpty(rspEmpty),
    .softReset(softReset)
  );

  initial begin
    repeat (200000) @(posedge tck);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkWord(input int k);
    logic [31:0] h = 32'h9E37_79B9 * (k + 3);
    return {8'h80 | 8'(k), h, ~h};
  endfunction

  // capture, shift n bits, update; tdo recorded before each shift edge
  task automatic scan(input logic [3:0] ir, input int n,
                      input logic [4*W-1:0] din, output logic [4*W-1:0] dout);
    irValue = ir; dout = '0;
    captureDr = 1; tick(); captureDr = 0;
    shiftDr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i]; dout[i] = tdo; tick();
    end
    shiftDr = 0; tdi = 0;
    updateDr = 1; tick(); updateDr = 0;
    tick();
  endtask

  logic [4*W-1:0] dout, din;

  initial begin
    #1;
    check("R1 reset softReset", W'(softReset), '0);
    check("R1 reset cmdPush", W'(cmdPush), '0);
    tick(); tick();
    rstN = 1; tick();
    check("R1 released rspPop", W'(rspPop), '0);
    check("R1 released softReset", W'(softReset), '0);

    // R2: bypass codes, 8-bit pattern through 1-bit delay
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 5) continue;
      din = '0; din[7:0] = 8'(8'h5B ^ c * 17);
      scan(4'(c), 8, din, dout);
      check("R2 bypass delay", W'(dout[7:0]), W'({din[6:0], 1'b0}));
    end

    // R6: exhaustive free count sweep
    for (int v = 0; v < 256; v++) begin
      cmdFree = 8'(v);
      scan(4'h2, 8, '0, dout);
      check("R6 free count", W'(dout[7:0]), W'(v));
    end

    // R10 and R5: ready bit and read from empty queue
    scan(4'h4, 1, '0, dout);
    check("R10 ready empty", W'(dout[0]), '0);
    scan(4'h1, W, '0, dout);
    check("R5 empty read zero", dout[W-1:0], '0);
    check("R5 no pop", W'(popCount), '0);

    // R3 R4 R5: three words queued, four streamed
    for (int k = 0; k < 3; k++) begin rspMem[k] = mkWord(k); end
    wrPtr = 3;
    scan(4'h4, 1, '0, dout);
    check("R10 ready full", W'(dout[0]), W'(1));
    scan(4'h1, 4*W, '0, dout);
    check("R3 first word", dout[W-1:0], mkWord(0));
    check("R4 second word", dout[2*W-1:W], mkWord(1));
    check("R4 third word", dout[3*W-1:2*W], mkWord(2));
    check("R5 drained word zero", dout[4*W-1:3*W], '0);
    check("R4 pop count", W'(popCount), W'(3));

    // R7 R8 R9: two whole words and a partial
    din = '0;
    din[W-1:0] = mkWord(10); din[2*W-1:W] = mkWord(11); din[2*W+29:2*W] = '1;
    scan(4'h3, 2*W + 30, din, dout);
    check("R8 push count", W'(pushCount), W'(2));
    check("R7 first pushed", pushed[0], mkWord(10));
    check("R8 second pushed", pushed[1], mkWord(11));
    din = '0; din[W-1:0] = mkWord(12);
    scan(4'h3, W, din, dout);
    check("R9 restart after partial", pushed[2], mkWord(12));
    check("R9 one more push", W'(pushCount), W'(3));

    // R11: flag set, read back, foreign update, clear
    din = '0; din[0] = 1;
    scan(4'h5, 1, din, dout);
    check("R11 flag set", W'(softReset), W'(1));
    scan(4'h5, 1, din, dout);
    check("R11 flag readback", W'(dout[0]), W'(1));
    din[0] = 0;
    scan(4'h0, 1, din, dout);
    check("R11 foreign update keeps", W'(softReset), W'(1));
    scan(4'h5, 1, din, dout);
    check("R11 flag cleared", W'(softReset), '0);
    check("R11 no stray push", W'(pushCount), W'(3));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule